// File: doc/BRIEF.md
# Accelerator Memory Permission Checker

This block guards the shared memory path of an accelerator that cannot be trusted. Each read or write that the accelerator issues is already a physical address. The block checks that address against a flat table in memory before the access may go ahead. The table has one read bit and one write bit for every physical page. Each accelerator ID has its own table, located by a base address that the host programs.

Table bytes fetched from memory are kept in a small local cache of permission bytes, so most checks never reach the table. An access that its bits do not allow is refused. The address, ID and direction of the first refused access are captured, and an interrupt to the host stays raised until the host clears it. The host can also flush the cached bytes of one ID after it removes rights from that ID.

Requests are taken one at a time. A miss in the cache stalls the request port until the table byte comes back on the fill interface.

Top module: `acc_perm_checker`

## Requirements
- R1: After reset, `req_ready` is high and `irq`, `rsp_valid` and `fill_req_valid` are low. No ID has a valid table base.
- R2: A request whose ID has no valid table base is denied in the cycle after acceptance, and no fill is issued for it.
- R3: The page number is the address shifted right by 12. A fill fetches the byte at table base plus `addr >> 14`. Inside that byte, the slot s = `addr[13:12]` keeps its read bit at position 2s and its write bit at position 2s+1.
- R4: A read is granted only if its read bit is 1. A write is granted only if its write bit is 1.
- R5: On a miss, `fill_req_valid` rises in the cycle after acceptance. It and `fill_req_addr` stay unchanged, and `req_ready` stays low, until `fill_rsp_valid` is seen. The response follows one cycle after the fill data.
- R6: A cache line holds one table byte, which covers four pages. It is tagged by ID and byte index. A hit answers one cycle after acceptance with no fill. The same byte index under another ID is a miss.
- R7: Fills take the cache lines in rotating order, so a line is replaced after `LINES` further fills.
- R8: `inv_valid` removes every cached line of `inv_id` and keeps the lines of all other IDs.
- R9: A denial raises `irq` in the same cycle as the response. It captures the address, ID and direction in `viol_addr`, `viol_id` and `viol_write`. Later denials do not overwrite these values while `irq` is high.
- R10: `irq_clear` drops `irq` on the next edge.
- R11: Writing `cfg_we` with `cfg_en` low makes the ID's base invalid, so its requests are denied again. Writing it with a new base makes later fills use that base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted on this edge |
| req_addr | input | ADDR_W | Physical address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_id | input | ID_W | Accelerator ID |
| rsp_valid | output | 1 | Verdict valid for one cycle |
| rsp_grant | output | 1 | 1 = allowed, 0 = refused |
| fill_req_valid | output | 1 | Table byte fetch pending |
| fill_req_addr | output | TBL_AW | Table byte address |
| fill_rsp_valid | input | 1 | Table byte returned |
| fill_rsp_data | input | 8 | Returned table byte |
| cfg_we | input | 1 | Write a table base |
| cfg_id | input | ID_W | ID whose base is written |
| cfg_en | input | 1 | Base is valid |
| cfg_base | input | TBL_AW | Table base address |
| inv_valid | input | 1 | Flush the cached lines of one ID |
| inv_id | input | ID_W | ID to flush |
| irq | output | 1 | Violation interrupt |
| irq_clear | input | 1 | Host clears the interrupt |
| viol_addr | output | ADDR_W | Captured faulting address |
| viol_id | output | ID_W | Captured faulting ID |
| viol_write | output | 1 | Captured direction |

## Verification
Some properties are checked by assertions on every cycle. These are: the fill request stays valid and stable while it waits, no request is accepted during a fill, every denial comes with a raised interrupt, the captured violation record stays put until cleared, and at most one cache line hits. The correctness of the decisions themselves can only be shown by the bench scenarios. This covers the table address arithmetic, the slot and bit selection, the grant values, the hit and miss pattern under rotating replacement, the per-ID flush, and the effect of reprogramming a base. The bench sweeps every page of a small address space for several IDs in both directions, against an arithmetic table and a model of the cache.

// File: rtl/acp_pkg.sv
package acp_pkg;

    localparam int unsigned SLOTS_LOG2 = 2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } acp_state_e;

    // Slot s keeps its read bit at 2s and its write bit at 2s+1.
    function automatic logic perm_bit(input logic [7:0] tbyte,
                                      input logic [1:0] slot,
                                      input logic       is_wr);
        return tbyte[{slot, is_wr}];
    endfunction

endpackage

// File: rtl/acp_base_regs.sv
module acp_base_regs #(
    parameter int unsigned ID_W   = 2,
    parameter int unsigned TBL_AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic              cfg_en,
    input  logic [TBL_AW-1:0] cfg_base,
    input  logic [ID_W-1:0]   rd_id,
    output logic [TBL_AW-1:0] rd_base,
    output logic              rd_valid
);
    localparam int unsigned NUM_ACC = 1 << ID_W;

    logic [NUM_ACC-1:0][TBL_AW-1:0] base_d, base_q;
    logic [NUM_ACC-1:0]             en_d,   en_q;

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_slot
        always_comb begin
            base_d[g] = base_q[g];
            en_d[g]   = en_q[g];
            if (cfg_we && (cfg_id == ID_W'(g))) begin
                base_d[g] = cfg_base;
                en_d[g]   = cfg_en;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[g] <= '0;
                en_q[g]   <= 1'b0;
            end else begin
                base_q[g] <= base_d[g];
                en_q[g]   <= en_d[g];
            end
        end
    end

    assign rd_base  = base_q[rd_id];
    assign rd_valid = en_q[rd_id];

endmodule

// File: rtl/acp_perm_cache.sv
module acp_perm_cache #(
    parameter int unsigned LINES = 4,
    parameter int unsigned ID_W  = 2,
    parameter int unsigned IDX_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ID_W-1:0]  lk_id,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_hit,
    output logic [7:0]       lk_data,
    input  logic             fill_we,
    input  logic [ID_W-1:0]  fill_id,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [7:0]       fill_data,
    input  logic             inv_valid,
    input  logic [ID_W-1:0]  inv_id
);
    localparam int unsigned PTR_W = (LINES > 1) ? $clog2(LINES) : 1;

    typedef struct packed {
        logic [LINES-1:0]            vld;
        logic [LINES-1:0][ID_W-1:0]  tid;
        logic [LINES-1:0][IDX_W-1:0] tidx;
        logic [LINES-1:0][7:0]       data;
        logic [PTR_W-1:0]            rr;
    } cache_s;

    cache_s s_d, s_q;
    logic [LINES-1:0] hit_vec;

    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign hit_vec[g] = s_q.vld[g] && (s_q.tid[g] == lk_id) && (s_q.tidx[g] == lk_idx);
    end

    always_comb begin
        lk_data = '0;
        for (int i = 0; i < LINES; i++) begin
            if (hit_vec[i]) lk_data = lk_data | s_q.data[i];
        end
    end
    assign lk_hit = |hit_vec;

    always_comb begin
        s_d = s_q;
        if (inv_valid) begin
            for (int i = 0; i < LINES; i++) begin
                if (s_q.tid[i] == inv_id) s_d.vld[i] = 1'b0;
            end
        end
        if (fill_we) begin
            s_d.vld[s_q.rr]  = 1'b1;
            s_d.tid[s_q.rr]  = fill_id;
            s_d.tidx[s_q.rr] = fill_idx;
            s_d.data[s_q.rr] = fill_data;
            s_d.rr = (s_q.rr == PTR_W'(LINES - 1)) ? '0 : s_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R6

endmodule

// File: rtl/acp_viol_status.sv
module acp_viol_status #(
    parameter int unsigned ADDR_W = 34,
    parameter int unsigned ID_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [ID_W-1:0]   evt_id,
    input  logic              evt_wr,
    input  logic              clear,
    output logic              irq,
    output logic [ADDR_W-1:0] viol_addr,
    output logic [ID_W-1:0]   viol_id,
    output logic              viol_write
);
    typedef struct packed {
        logic              irq;
        logic [ADDR_W-1:0] addr;
        logic [ID_W-1:0]   id;
        logic              wr;
    } viol_s;

    viol_s v_d, v_q;

    always_comb begin
        v_d = v_q;
        if (evt && (!v_q.irq || clear)) begin
            v_d.irq  = 1'b1;
            v_d.addr = evt_addr;
            v_d.id   = evt_id;
            v_d.wr   = evt_wr;
        end else if (clear) begin
            v_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign irq        = v_q.irq;
    assign viol_addr  = v_q.addr;
    assign viol_id    = v_q.id;
    assign viol_write = v_q.wr;

    AST_VIOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clear |=> irq && $stable(viol_addr) && $stable(viol_id)); // R9
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clear && !evt |=> !irq); // R10

endmodule

// File: rtl/acc_perm_checker.sv
module acc_perm_checker #(
    parameter int unsigned ADDR_W     = 34,
    parameter int unsigned ID_W       = 2,
    parameter int unsigned TBL_AW     = 32,
    parameter int unsigned LINES      = 4,
    parameter int unsigned PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [ID_W-1:0]   req_id,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              fill_req_valid,
    output logic [TBL_AW-1:0] fill_req_addr,
    input  logic              fill_rsp_valid,
    input  logic [7:0]        fill_rsp_data,
    input  logic              cfg_we,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic              cfg_en,
    input  logic [TBL_AW-1:0] cfg_base,
    input  logic              inv_valid,
    input  logic [ID_W-1:0]   inv_id,
    output logic              irq,
    input  logic              irq_clear,
    output logic [ADDR_W-1:0] viol_addr,
    output logic [ID_W-1:0]   viol_id,
    output logic              viol_write
);
    import acp_pkg::*;

    localparam int unsigned IDX_LO = PAGE_SHIFT + SLOTS_LOG2;
    localparam int unsigned IDX_W  = ADDR_W - IDX_LO;

    typedef struct packed {
        acp_state_e        st;
        logic [ADDR_W-1:0] p_addr;
        logic [ID_W-1:0]   p_id;
        logic              p_wr;
        logic [TBL_AW-1:0] f_addr;
        logic              rsp_v;
        logic              rsp_g;
    } ctl_s;

    ctl_s c_d, c_q;

    logic [TBL_AW-1:0] base;
    logic              base_ok;
    logic              hit;
    logic [7:0]        hit_data;
    logic              fill_we;
    logic              evt;
    logic [ADDR_W-1:0] evt_addr;
    logic [ID_W-1:0]   evt_id;
    logic              evt_wr;

    logic [IDX_W-1:0] req_idx, p_idx;
    logic [1:0]       req_slot, p_slot;

    assign req_idx  = req_addr[ADDR_W-1:IDX_LO];
    assign req_slot = req_addr[IDX_LO-1:PAGE_SHIFT];
    assign p_idx    = c_q.p_addr[ADDR_W-1:IDX_LO];
    assign p_slot   = c_q.p_addr[IDX_LO-1:PAGE_SHIFT];

    acp_base_regs #(.ID_W(ID_W), .TBL_AW(TBL_AW)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_id   (cfg_id),
        .cfg_en   (cfg_en),
        .cfg_base (cfg_base),
        .rd_id    (req_id),
        .rd_base  (base),
        .rd_valid (base_ok)
    );

    acp_perm_cache #(.LINES(LINES), .ID_W(ID_W), .IDX_W(IDX_W)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_id     (req_id),
        .lk_idx    (req_idx),
        .lk_hit    (hit),
        .lk_data   (hit_data),
        .fill_we   (fill_we),
        .fill_id   (c_q.p_id),
        .fill_idx  (p_idx),
        .fill_data (fill_rsp_data),
        .inv_valid (inv_valid),
        .inv_id    (inv_id)
    );

    acp_viol_status #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_viol (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .evt_addr   (evt_addr),
        .evt_id     (evt_id),
        .evt_wr     (evt_wr),
        .clear      (irq_clear),
        .irq        (irq),
        .viol_addr  (viol_addr),
        .viol_id    (viol_id),
        .viol_write (viol_write)
    );

    always_comb begin
        c_d      = c_q;
        c_d.rsp_v = 1'b0;
        c_d.rsp_g = 1'b0;
        fill_we  = 1'b0;
        evt      = 1'b0;
        evt_addr = req_addr;
        evt_id   = req_id;
        evt_wr   = req_write;
        case (c_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!base_ok) begin
                        c_d.rsp_v = 1'b1;
                        evt       = 1'b1;
                    end else if (hit) begin
                        c_d.rsp_v = 1'b1;
                        c_d.rsp_g = perm_bit(hit_data, req_slot, req_write);
                        evt       = !c_d.rsp_g;
                    end else begin
                        c_d.st     = ST_FILL;
                        c_d.p_addr = req_addr;
                        c_d.p_id   = req_id;
                        c_d.p_wr   = req_write;
                        c_d.f_addr = base + TBL_AW'(req_idx);
                    end
                end
            end
            default: begin
                evt_addr = c_q.p_addr;
                evt_id   = c_q.p_id;
                evt_wr   = c_q.p_wr;
                if (fill_rsp_valid) begin
                    fill_we   = 1'b1;
                    c_d.rsp_v = 1'b1;
                    c_d.rsp_g = perm_bit(fill_rsp_data, p_slot, c_q.p_wr);
                    evt       = !c_d.rsp_g;
                    c_d.st    = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign req_ready      = (c_q.st == ST_IDLE);
    assign rsp_valid      = c_q.rsp_v;
    assign rsp_grant      = c_q.rsp_g;
    assign fill_req_valid = (c_q.st == ST_FILL);
    assign fill_req_addr  = c_q.f_addr;

    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid && !fill_rsp_valid |=> fill_req_valid && $stable(fill_req_addr)); // R5
    AST_NO_ACCEPT_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid |-> !req_ready); // R5
    AST_DENY_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_grant |-> irq); // R9
    AST_FILL_ENDS_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid && fill_rsp_valid |=> rsp_valid && !fill_req_valid); // R5

endmodule

// File: tb/tb_acc_perm_checker.sv
module tb_acc_perm_checker;
    localparam int ADDR_W = 18;
    localparam int ID_W   = 2;
    localparam int TBL_AW = 16;
    localparam int LINES  = 4;
    localparam int PAGES  = 1 << (ADDR_W - 12);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              req_valid = 0, req_write = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [ID_W-1:0]   req_id = '0;
    logic              req_ready, rsp_valid, rsp_grant;
    logic              fill_req_valid;
    logic [TBL_AW-1:0] fill_req_addr;
    logic              fill_rsp_valid = 0;
    logic [7:0]        fill_rsp_data = '0;
    logic              cfg_we = 0, cfg_en = 0;
    logic [ID_W-1:0]   cfg_id = '0;
    logic [TBL_AW-1:0] cfg_base = '0;
    logic              inv_valid = 0;
    logic [ID_W-1:0]   inv_id = '0;
    logic              irq, irq_clear = 0, viol_write;
    logic [ADDR_W-1:0] viol_addr;
    logic [ID_W-1:0]   viol_id;

    acc_perm_checker #(.ADDR_W(ADDR_W), .ID_W(ID_W), .TBL_AW(TBL_AW), .LINES(LINES)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_id(req_id),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
        .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data),
        .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_en(cfg_en), .cfg_base(cfg_base),
        .inv_valid(inv_valid), .inv_id(inv_id),
        .irq(irq), .irq_clear(irq_clear),
        .viol_addr(viol_addr), .viol_id(viol_id), .viol_write(viol_write)
    );

    int n_chk = 0, n_bad = 0;

    // bench models
    int m_base [4];
    bit m_bv   [4];
    bit m_vld  [LINES];
    int m_tid  [LINES];
    int m_tidx [LINES];
    int m_rr = 0;
    bit irq_m = 0;
    int va_m = 0, vid_m = 0, vwr_m = 0;

    function automatic int tbl_byte(int a);
        return (a * 53 + (a >> 3) + 7) & 8'hFF;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit m_hit(int id, int idx);
        for (int i = 0; i < LINES; i++)
            if (m_vld[i] && m_tid[i] == id && m_tidx[i] == idx) return 1;
        return 0;
    endfunction

    task automatic do_req(int id, int page, bit wr, string tag);
        int idx, slot, tbl, off;
        bit miss, grant;
        off  = (page * 97 + id * 13) & 12'hFFF;
        idx  = page >> 2;
        slot = page & 3;
        tbl  = (m_base[id] + idx) & 16'hFFFF;
        miss = m_bv[id] && !m_hit(id, idx);
        grant = m_bv[id] && (((tbl_byte(tbl) >> (2 * slot + int'(wr))) & 1) == 1);
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " ready before request"}, req_ready, 1);
        req_valid = 1; req_id = ID_W'(id); req_write = wr;
        req_addr = ADDR_W'((page << 12) | off);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        chk(fill_req_valid == miss, {tag, " fill issued iff miss (R6 R7)"}, fill_req_valid, miss);
        if (fill_req_valid) begin
            chk(int'(fill_req_addr) == tbl, {tag, " table byte address R3"}, fill_req_addr, tbl);
            chk(!req_ready && !rsp_valid, {tag, " stall during fill R5"}, {req_ready, rsp_valid}, 0);
            @(negedge clk);
            @(negedge clk);
            chk(fill_req_valid && int'(fill_req_addr) == tbl, {tag, " fill held R5"}, fill_req_addr, tbl);
            fill_rsp_valid = 1;
            fill_rsp_data  = 8'(tbl_byte(int'(fill_req_addr)));
            @(negedge clk);
            fill_rsp_valid = 0;
            m_vld[m_rr] = 1; m_tid[m_rr] = id; m_tidx[m_rr] = idx;
            m_rr = (m_rr + 1) % LINES;
        end
        chk(rsp_valid == 1'b1, {tag, " response present R5 R6"}, rsp_valid, 1);
        chk(rsp_grant == grant, {tag, " grant value R4"}, rsp_grant, grant);
        if (!grant) begin
            if (!irq_m) begin
                irq_m = 1; va_m = (page << 12) | off; vid_m = id; vwr_m = int'(wr);
            end
            chk(irq == 1'b1, {tag, " irq on deny R9"}, irq, 1);
            chk(int'(viol_addr) == va_m && int'(viol_id) == vid_m && int'(viol_write) == vwr_m,
                {tag, " violation record R9"}, viol_addr, va_m);
        end
    endtask

    task automatic clear_irq(string tag);
        @(negedge clk); irq_clear = 1;
        @(negedge clk); irq_clear = 0;
        irq_m = 0;
        chk(irq == 1'b0, {tag, " irq cleared R10"}, irq, 0);
    endtask

    task automatic set_base(int id, bit en, int b);
        @(negedge clk);
        cfg_we = 1; cfg_id = ID_W'(id); cfg_en = en; cfg_base = TBL_AW'(b);
        @(negedge clk); cfg_we = 0;
        m_bv[id] = en; m_base[id] = b;
    endtask

    task automatic flush(int id);
        @(negedge clk); inv_valid = 1; inv_id = ID_W'(id);
        @(negedge clk); inv_valid = 0;
        for (int i = 0; i < LINES; i++) if (m_tid[i] == id) m_vld[i] = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_bv[i] = 0; m_base[i] = 0; end
        for (int i = 0; i < LINES; i++) begin m_vld[i] = 0; m_tid[i] = 0; m_tidx[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !irq && !rsp_valid && !fill_req_valid, "R1 reset outputs",
            {req_ready, irq, rsp_valid, fill_req_valid}, 4'b1000);
        // R1 R2 no base: denied without fill
        do_req(0, 5, 0, "R1 R2 unprogrammed");
        clear_irq("R10 first");

        set_base(0, 1, 16'h0100);
        set_base(1, 1, 16'h0230);
        // sweep R3 R4 R6 R7 over all pages, two ids, both directions
        for (int p = 0; p < PAGES; p++) begin
            for (int id = 0; id < 2; id++) begin
                for (int w = 0; w < 2; w++) begin
                    do_req(id, p, w[0], "R4 sweep");
                    if (irq_m) clear_irq("R10 sweep");
                end
            end
        end

        // R2 id without base
        do_req(2, 9, 1, "R2 id2");
        clear_irq("R10 id2");

        // R7 rotation: five distinct bytes then revisit
        flush(0); flush(1);
        for (int b = 0; b < 5; b++) begin
            do_req(0, b * 4, 0, "R7 fill");
            if (irq_m) clear_irq("R10 r7");
        end
        for (int b = 0; b < 5; b++) begin
            do_req(0, b * 4 + 1, 1, "R7 revisit");
            if (irq_m) clear_irq("R10 r7b");
        end

        // R8 per-id flush
        do_req(0, 40, 0, "R8 prime0");
        if (irq_m) clear_irq("R10 r8");
        do_req(1, 40, 0, "R8 prime1");
        if (irq_m) clear_irq("R10 r8");
        flush(0);
        do_req(1, 41, 0, "R8 other id kept");
        if (irq_m) clear_irq("R10 r8");
        do_req(0, 41, 0, "R8 flushed id misses");
        if (irq_m) clear_irq("R10 r8");

        // R9 first violation held
        do_req(3, 12, 0, "R9 first");
        do_req(3, 20, 1, "R9 second kept first");
        chk(int'(viol_addr) == va_m && va_m == ((12 << 12) | ((12 * 97 + 39) & 12'hFFF)),
            "R9 record not overwritten", viol_addr, va_m);
        clear_irq("R10 after two");

        // R11 disable and rebase
        set_base(1, 0, 16'h0230);
        do_req(1, 3, 0, "R11 disabled");
        clear_irq("R10 r11");
        set_base(1, 1, 16'h0777);
        flush(1);
        for (int p = 0; p < 8; p++) begin
            do_req(1, p, p[0], "R11 rebased");
            if (irq_m) clear_irq("R10 r11b");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule